// File: doc/BRIEF.md
# Lockable Two-Stage Watchdog Timer

This peripheral watches for a stalled processor. A 32-bit down-counter steps once for every sixteen input clock cycles. When the count runs out the first time, the block raises a level interrupt and starts over from the programmed load value. If software has not acknowledged that interrupt by the time the count runs out again, the block raises a reset request. That request stays high until the block itself is reset. Software keeps the system alive by "kicking" the timer: any write to the kick register clears the interrupt and restarts the count.

Software reaches the block through a plain 32-bit write/read register port. A key register guards every other writable register. Until the exact 32-bit key is written there, writes to the load, control and kick registers are dropped. Any other value written to the key register closes the guard again. Reads are always allowed and return the state of the addressed register in the same cycle.

Top module: `lock_wdog`

## Requirements
- R1: After reset the key register (offset 0xC00) reads 1, control (0x008) reads 0, load (0x000) and live count (0x004) both read 0xFFFFFFFF, and `irq_o` and `rst_req_o` are low.
- R2: Writing 0x1ACCE551 to offset 0xC00 opens the guard, and the register then reads 0. Writing any other value, for example 0x00000001, closes it, and the register reads 1 again.
- R3: While the guard is closed, writes to load (0x000), control (0x008) and kick (0x00C) have no effect.
- R4: A write to load (0x000) stores the value, which then reads back, and at once reloads the live count. A stored value of 0 counts as 1, so the live count never reads 0.
- R5: With control bit 0 set, the live count at 0x004 drops by one every 16 clock cycles, measured from the cycle after control was written or the count was reloaded. With bit 0 clear, the count holds.
- R6: When a prescaler step finds the live count at 1, the count reloads from the load value and the interrupt becomes pending. `irq_o` shows the pending state only while control bit 0 is set.
- R7: `rst_req_o` rises when an expiry happens while the interrupt is already pending and control bit 1 is set. With bit 1 clear, a second expiry raises no reset request.
- R8: Once high, `rst_req_o` stays high through kicks and register writes until `rst_ni` is asserted.
- R9: Any write to kick (0x00C) while the guard is open clears the pending interrupt and reloads the live count. If the kick lands in the same cycle as an expiry, the kick wins: no interrupt becomes pending and no reset request is raised.
- R10: Control (0x008) reads back its two stored bits in bits [1:0] and zeros above them. Kick (0x00C) and unmapped offsets read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| bus_we_i | input | 1 | Write strobe, one write per cycle it is high |
| bus_addr_i | input | 12 | Byte offset of the register |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data for `bus_addr_i`, combinational |
| irq_o | output | 1 | Level interrupt, first-stage expiry |
| rst_req_o | output | 1 | Sticky reset request, second-stage expiry |

## Verification
Two events can land on the same clock edge: a kick write and the expiry step of the counter. If the kick wins, the system stays alive. If the expiry wins, a pending interrupt escalates into a reset. The bench waits for an interrupt to rise, counts exactly one timeout period of prescaler steps, and times a kick write so that it is sampled on the edge where the second expiry would fall. The bench judges the result by checking that `rst_req_o` stays low, that `irq_o` is clear and that the live count reads the full load value. A cycle-level reference model is compared against the outputs on every cycle around that edge.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
  localparam int ADDR_W = 12;
  localparam int DATA_W = 32;
  localparam int CTRL_W = 2;

  localparam logic [ADDR_W-1:0] OFF_LOAD  = 12'h000;
  localparam logic [ADDR_W-1:0] OFF_COUNT = 12'h004;
  localparam logic [ADDR_W-1:0] OFF_CTRL  = 12'h008;
  localparam logic [ADDR_W-1:0] OFF_KICK  = 12'h00C;
  localparam logic [ADDR_W-1:0] OFF_LOCK  = 12'hC00;

  localparam logic [DATA_W-1:0] UNLOCK_KEY = 32'h1ACCE551;

  typedef struct packed {
    logic rst_en;
    logic run;
  } ctrl_t;
endpackage

// File: rtl/wdog_prescale.sv
module wdog_prescale #(
  parameter int DIV = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic clr_i,
  output logic tick_o
);
  localparam int PW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [PW-1:0] LAST = PW'(DIV - 1);

  logic [PW-1:0] pcnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              pcnt_q <= '0;
    else if (clr_i || !en_i)  pcnt_q <= '0;
    else if (pcnt_q == LAST)  pcnt_q <= '0;
    else                      pcnt_q <= pcnt_q + 1'b1;
  end

  assign tick_o = en_i && (pcnt_q == LAST);
endmodule

// File: rtl/wdog_regs.sv
module wdog_regs
  import wdog_pkg::*;
#(
  parameter int CNT_W = DATA_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bus_we_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic [DATA_W-1:0] bus_wdata_i,
  output logic [DATA_W-1:0] bus_rdata_o,
  input  logic [CNT_W-1:0]  count_i,
  output logic [CNT_W-1:0]  load_q_o,
  output logic [CNT_W-1:0]  load_nxt_o,
  output ctrl_t             ctrl_o,
  output logic              lock_o,
  output logic              reload_o,
  output logic              kick_o
);
  logic [CNT_W-1:0] load_q;
  ctrl_t            ctrl_q;
  logic             lock_q;
  logic             open_wr, load_wr, ctrl_wr, lock_wr;

  assign open_wr = bus_we_i && !lock_q;
  assign load_wr = open_wr && (bus_addr_i == OFF_LOAD);
  assign ctrl_wr = open_wr && (bus_addr_i == OFF_CTRL);
  assign kick_o  = open_wr && (bus_addr_i == OFF_KICK);
  assign lock_wr = bus_we_i && (bus_addr_i == OFF_LOCK);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      load_q <= '1;
      ctrl_q <= '0;
      lock_q <= 1'b1;
    end else begin
      if (load_wr) load_q <= bus_wdata_i[CNT_W-1:0];
      if (ctrl_wr) ctrl_q <= ctrl_t'(bus_wdata_i[CTRL_W-1:0]);
      if (lock_wr) lock_q <= (bus_wdata_i != UNLOCK_KEY);
    end
  end

  assign load_nxt_o = load_wr ? bus_wdata_i[CNT_W-1:0] : load_q;
  assign reload_o   = load_wr || kick_o;
  assign load_q_o   = load_q;
  assign ctrl_o     = ctrl_q;
  assign lock_o     = lock_q;

  always_comb begin
    bus_rdata_o = '0;
    unique case (bus_addr_i)
      OFF_LOAD:  bus_rdata_o[CNT_W-1:0]  = load_q;
      OFF_COUNT: bus_rdata_o[CNT_W-1:0]  = count_i;
      OFF_CTRL:  bus_rdata_o[CTRL_W-1:0] = ctrl_q;
      OFF_LOCK:  bus_rdata_o[0]          = lock_q;
      default:   bus_rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/wdog_core.sv
module wdog_core #(
  parameter int CNT_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             reload_i,
  input  logic             kick_i,
  input  logic             rst_en_i,
  input  logic [CNT_W-1:0] load_i,
  output logic [CNT_W-1:0] count_o,
  output logic             irq_pend_o,
  output logic             rst_req_o
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [CNT_W-1:0] count_q, load_eff;
  logic             pend_q, rreq_q, expire;

  assign load_eff = (load_i == '0) ? ONE : load_i;
  // reload from the bus wins over a coincident expiry
  assign expire   = tick_i && (count_q == ONE) && !reload_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      count_q <= '1;
      pend_q  <= 1'b0;
      rreq_q  <= 1'b0;
    end else begin
      if (reload_i || expire) count_q <= load_eff;
      else if (tick_i)        count_q <= count_q - ONE;

      if (kick_i)      pend_q <= 1'b0;
      else if (expire) pend_q <= 1'b1;

      if (expire && pend_q && rst_en_i) rreq_q <= 1'b1;
    end
  end

  assign count_o    = count_q;
  assign irq_pend_o = pend_q;
  assign rst_req_o  = rreq_q;
endmodule

// File: rtl/lock_wdog.sv
module lock_wdog
  import wdog_pkg::*;
#(
  parameter int DIV   = 16,
  parameter int CNT_W = DATA_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bus_we_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic [DATA_W-1:0] bus_wdata_i,
  output logic [DATA_W-1:0] bus_rdata_o,
  output logic              irq_o,
  output logic              rst_req_o
);
  logic [CNT_W-1:0] load_q, load_nxt, count_q;
  ctrl_t            ctrl_q;
  logic             lock_q, reload, kick, tick, irq_pend;

  wdog_regs #(.CNT_W(CNT_W)) u_regs (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .bus_we_i    (bus_we_i),
    .bus_addr_i  (bus_addr_i),
    .bus_wdata_i (bus_wdata_i),
    .bus_rdata_o (bus_rdata_o),
    .count_i     (count_q),
    .load_q_o    (load_q),
    .load_nxt_o  (load_nxt),
    .ctrl_o      (ctrl_q),
    .lock_o      (lock_q),
    .reload_o    (reload),
    .kick_o      (kick)
  );

  wdog_prescale #(.DIV(DIV)) u_pre (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (ctrl_q.run),
    .clr_i  (reload),
    .tick_o (tick)
  );

  wdog_core #(.CNT_W(CNT_W)) u_core (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .tick_i     (tick),
    .reload_i   (reload),
    .kick_i     (kick),
    .rst_en_i   (ctrl_q.rst_en),
    .load_i     (load_nxt),
    .count_o    (count_q),
    .irq_pend_o (irq_pend),
    .rst_req_o  (rst_req_o)
  );

  assign irq_o = irq_pend && ctrl_q.run;
endmodule

// File: rtl/wdog_checker.sv
module wdog_checker
  import wdog_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              bus_we_i,
  input logic [ADDR_W-1:0] bus_addr_i,
  input logic              lock_q,
  input logic [CNT_W-1:0]  load_q,
  input logic [CNT_W-1:0]  count_q,
  input logic [1:0]        ctrl_q,
  input logic              reload,
  input logic              kick,
  input logic              tick,
  input logic              irq_pend,
  input logic              rst_req_o
);
  p_locked_load_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lock_q && bus_we_i && (bus_addr_i == OFF_LOAD) |=> $stable(load_q));

  p_count_nonzero_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    count_q != '0);

  p_count_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick && !reload |=> $stable(count_q));

  p_irq_from_tick_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_pend) |-> $past(tick));

  p_rst_needs_irq_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rst_req_o) |-> $past(irq_pend) && $past(ctrl_q[1]));

  p_rst_sticky_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_req_o |=> rst_req_o);

  p_kick_clears_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    kick |=> !irq_pend);
endmodule

bind lock_wdog wdog_checker #(.CNT_W(CNT_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .bus_we_i   (bus_we_i),
  .bus_addr_i (bus_addr_i),
  .lock_q     (lock_q),
  .load_q     (load_q),
  .count_q    (count_q),
  .ctrl_q     (ctrl_q),
  .reload     (reload),
  .kick       (kick),
  .tick       (tick),
  .irq_pend   (irq_pend),
  .rst_req_o  (rst_req_o)
);

// File: tb/tb_lock_wdog.sv
module tb_lock_wdog;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        we = 1'b0;
  logic [11:0] addr = 12'h000;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq, rreq;

  int    n_chk = 0;
  int    n_err = 0;
  bit    done = 1'b0;
  string cur_req = "R1";

  localparam logic [31:0] KEY = 32'h1ACCE551;

  always #10 clk = ~clk;

  lock_wdog dut (
    .clk_i(clk), .rst_ni(rst_n), .bus_we_i(we), .bus_addr_i(addr),
    .bus_wdata_i(wdata), .bus_rdata_o(rdata), .irq_o(irq), .rst_req_o(rreq)
  );

  // behavioural reference
  int unsigned m_load = 32'hFFFFFFFF, m_cnt = 32'hFFFFFFFF, m_ctrl = 0, m_pc = 0;
  bit m_lock = 1, m_pend = 0, m_rst = 0;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_load = 32'hFFFFFFFF; m_cnt = 32'hFFFFFFFF; m_ctrl = 0; m_pc = 0;
      m_lock = 1; m_pend = 0; m_rst = 0;
    end else begin
      bit ld, kk, ct, lk, rl, tk, ex;
      int unsigned nl, eff;
      ld = we && !m_lock && addr == 12'h000;
      kk = we && !m_lock && addr == 12'h00C;
      ct = we && !m_lock && addr == 12'h008;
      lk = we && addr == 12'hC00;
      nl = ld ? wdata : m_load;
      eff = (nl == 0) ? 1 : nl;
      rl = ld || kk;
      tk = m_ctrl[0] && m_pc == 15;
      ex = tk && m_cnt == 1 && !rl;
      if (ex && m_pend && m_ctrl[1]) m_rst = 1;
      if (kk) m_pend = 0; else if (ex) m_pend = 1;
      if (rl || ex) m_cnt = eff; else if (tk) m_cnt = m_cnt - 1;
      if (rl || !m_ctrl[0] || m_pc == 15) m_pc = 0; else m_pc = m_pc + 1;
      m_load = nl;
      if (ct) m_ctrl = wdata & 3;
      if (lk) m_lock = (wdata != KEY);
    end
  end

  function automatic logic [31:0] m_read(logic [11:0] a);
    case (a)
      12'h000: return m_load;
      12'h004: return m_cnt;
      12'h008: return m_ctrl;
      12'hC00: return {31'b0, m_lock};
      default: return 32'h0;
    endcase
  endfunction

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // per-cycle comparison against the model, away from the active edge
  always @(negedge clk) begin
    if (!done) begin
      chk(cur_req, "model irq_o", {31'b0, irq}, {31'b0, m_pend && m_ctrl[0]});
      chk(cur_req, "model rst_req_o", {31'b0, rreq}, {31'b0, m_rst});
      chk(cur_req, "model rdata", rdata, m_read(addr));
    end
  end

  task automatic wr(logic [11:0] a, logic [31:0] d);
    @(posedge clk); #2;
    we = 1'b1; addr = a; wdata = d;
    @(posedge clk); #2;
    we = 1'b0;
  endtask

  task automatic expect_rd(string req, logic [11:0] a, logic [31:0] exp);
    addr = a; #1;
    chk(req, "read", rdata, exp);
  endtask

  task automatic cycles(int n);
    repeat (n) @(posedge clk);
    #2;
  endtask

  task automatic finish_run();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    cycles(3); rst_n = 1'b1; cycles(1);
    // R1 reset state
    cur_req = "R1";
    expect_rd("R1", 12'hC00, 32'h1);
    expect_rd("R1", 12'h008, 32'h0);
    expect_rd("R1", 12'h000, 32'hFFFFFFFF);
    expect_rd("R1", 12'h004, 32'hFFFFFFFF);
    chk("R1", "irq_o", {31'b0, irq}, 32'h0);
    chk("R1", "rst_req_o", {31'b0, rreq}, 32'h0);

    // R3 locked writes dropped
    cur_req = "R3";
    wr(12'h000, 32'h5);
    wr(12'h008, 32'h3);
    expect_rd("R3", 12'h000, 32'hFFFFFFFF);
    expect_rd("R3", 12'h008, 32'h0);

    // R2 open guard
    cur_req = "R2";
    wr(12'hC00, KEY);
    expect_rd("R2", 12'hC00, 32'h0);

    // R4 load write, zero treated as one
    cur_req = "R4";
    wr(12'h000, 32'h0);
    expect_rd("R4", 12'h000, 32'h0);
    expect_rd("R4", 12'h004, 32'h1);
    wr(12'h000, 32'h3);
    expect_rd("R4", 12'h004, 32'h3);

    // R5 hold while stopped, step every 16 cycles when running
    cur_req = "R5";
    cycles(20);
    expect_rd("R5", 12'h004, 32'h3);
    wr(12'h008, 32'h1);
    // R10 control readback
    expect_rd("R10", 12'h008, 32'h1);
    expect_rd("R10", 12'h00C, 32'h0);
    expect_rd("R10", 12'h100, 32'h0);
    addr = 12'h004;
    cycles(15);
    expect_rd("R5", 12'h004, 32'h3);
    cycles(1);
    expect_rd("R5", 12'h004, 32'h2);

    // R6 first expiry after 3 steps
    cur_req = "R6";
    cycles(31);
    chk("R6", "irq before expiry", {31'b0, irq}, 32'h0);
    cycles(1);
    chk("R6", "irq at expiry", {31'b0, irq}, 32'h1);
    expect_rd("R6", 12'h004, 32'h3);
    wr(12'h008, 32'h0);
    chk("R6", "irq masked", {31'b0, irq}, 32'h0);
    wr(12'h008, 32'h1);
    chk("R6", "irq unmasked", {31'b0, irq}, 32'h1);

    // R7 second expiry without reset enable
    cur_req = "R7";
    cycles(60);
    chk("R7", "no reset with bit1 clear", {31'b0, rreq}, 32'h0);

    // R9 kick
    cur_req = "R9";
    wr(12'h00C, 32'h0);
    chk("R9", "kick clears irq", {31'b0, irq}, 32'h0);
    expect_rd("R9", 12'h004, 32'h3);

    // R2/R3 re-lock: kick and load ignored
    cur_req = "R3";
    wr(12'h008, 32'h3);
    wr(12'hC00, 32'h1);
    expect_rd("R2", 12'hC00, 32'h1);
    while (!irq) cycles(1);
    wr(12'h00C, 32'h0);
    chk("R3", "locked kick ignored", {31'b0, irq}, 32'h1);
    wr(12'h000, 32'h9);
    expect_rd("R3", 12'h000, 32'h3);

    // R7 escalation with bit1 set
    cur_req = "R7";
    while (!rreq) cycles(1);
    chk("R7", "reset raised", {31'b0, rreq}, 32'h1);

    // R8 sticky until reset
    cur_req = "R8";
    wr(12'hC00, KEY);
    wr(12'h00C, 32'h0);
    wr(12'h008, 32'h0);
    cycles(5);
    chk("R8", "reset held", {31'b0, rreq}, 32'h1);
    rst_n = 1'b0; cycles(2); rst_n = 1'b1; cycles(1);
    chk("R8", "reset cleared", {31'b0, rreq}, 32'h0);

    // R9 kick coincident with second expiry
    cur_req = "R9";
    wr(12'hC00, KEY);
    wr(12'h000, 32'h3);
    wr(12'h008, 32'h3);
    while (!irq) cycles(1);
    cycles(46);
    wr(12'h00C, 32'h0);
    chk("R9", "collision no reset", {31'b0, rreq}, 32'h0);
    chk("R9", "collision no irq", {31'b0, irq}, 32'h0);
    expect_rd("R9", 12'h004, 32'h3);
    cycles(4);

    finish_run();
  end
endmodule